// File: doc/BRIEF.md
# Big-Endian Byte-Lane Steering Bridge

This block sits between a simple processor data port and a 32-bit bus that can select individual bytes. The processor gives a byte address, a two-bit access size and write data aligned to bit 0. For each request the bridge works out which of the four byte-select lines to drive and moves the write data onto those lanes. Lanes are assigned big-endian: the lowest byte address maps to the most significant lane.

When the bus acknowledges a read, the bridge uses the registered select lines to pick the addressed byte or halfword out of the returned word. It moves that value down to bit 0 and fills the unused upper bits with zeros. With each response it also reports the access size and the low address bits, both recovered from the select pattern.

The request is registered and held on the bus until acknowledge. The response is registered as well. Only one transfer can be in flight at a time.

Top module: `lane_bridge`

## Requirements
- R1: After reset, `busReq` and `rspValid` are low, `cpuReady` is high, and `rspRdata`, `rspSize` and `rspOffset` are zero.
- R2: Size code 00 (byte) at address offsets 0, 1, 2 and 3 drives `busSel` 1000, 0100, 0010 and 0001. Write data bits 7..0 go to bus bits 31..24, 23..16, 15..8 and 7..0 respectively, and every other bus bit is zero.
- R3: Size code 01 (halfword) at offset 0 or 1 drives `busSel` 1100, with write bits 15..0 placed on bus bits 31..16. At offset 2 or 3 it drives `busSel` 0011, with the same bits on bus bits 15..0.
- R4: Size code 10 (word) drives `busSel` 1111 and passes all 32 write bits unchanged.
- R5: Size code 11 drives `busSel` 0000 and all-zero `busWdata`.
- R6: A read with a single-lane select returns that lane's byte in `rspRdata` bits 7..0, with bits 31..8 zero.
- R7: A read with select 1100 returns bus bits 31..16 in `rspRdata` bits 15..0. Select 0011 returns bus bits 15..0. In both cases the upper half is zero. Select 1111 returns the whole word.
- R8: A read whose select is none of the seven legal patterns returns zero data.
- R9: `rspSize` is 00 for a one-lane select, 01 for 1100 or 0011, 10 for 1111, and 11 otherwise.
- R10: `rspOffset` is 00 for 1000, 1100 or 1111; 01 for 0100; 10 for 0010 or 0011; and 11 for 0001 or any other pattern.
- R11: A request accepted while `cpuValid` and `cpuReady` are high appears on `busReq`, `busWe`, `busAddr` (byte address bits above bit 1), `busSel` and `busWdata` on the next cycle. These outputs stay unchanged until `busAck`, and `cpuReady` stays low for that whole time. A `cpuValid` seen while busy is ignored.
- R12: A cycle with `busReq` and `busAck` both high ends the transfer: on the next cycle `busReq` is low and `rspValid` is high for exactly one cycle. A write response carries zero in `rspRdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | Processor request valid |
| cpuReady | output | 1 | Bridge can take a request |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Byte address |
| cpuSize | input | 2 | 00 byte, 01 halfword, 10 word, 11 invalid |
| cpuWdata | input | 32 | Right-aligned write data |
| busReq | output | 1 | Bus request strobe, held until acknowledge |
| busWe | output | 1 | Bus write enable |
| busAddr | output | ADDR_W-2 | Word address |
| busSel | output | 4 | Byte-lane selects, bit 3 = bits 31..24 |
| busWdata | output | 32 | Lane-steered write data |
| busAck | input | 1 | Bus acknowledge |
| busRdata | input | 32 | Bus read data |
| rspValid | output | 1 | One-cycle response strobe |
| rspRdata | output | 32 | Right-aligned, zero-filled read data |
| rspSize | output | 2 | Size decoded from select |
| rspOffset | output | 2 | Low address bits decoded from select |

## Verification
The bench builds the bridge with ADDR_W set to 12, so the word address is 10 bits wide. Each vector uses a different upper address, which shows whether the address field is registered and passed through intact rather than stuck or truncated. The four-lane, 8-bit granularity is fixed, so every size and offset combination is reachable: all sixteen write cases and all legal read select patterns. The invalid size code is the only route to an all-zero select, and the bench exercises it to reach the zero-return decode paths. Directed tests stall the acknowledge for several cycles while a second request is offered, and also apply reset while a transfer is in flight.

// File: rtl/lane_pkg.sv
package lane_pkg;

  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;
  localparam int LIDX_W = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_BAD  = 2'b11
  } accSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture processor request
    logic finish;  // bus acknowledged, capture response
  } laneCtrl_t;

endpackage

// File: rtl/lane_ctrl.sv
module lane_ctrl
  import lane_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cpuValid,
  input  logic      busAck,
  output logic      cpuReady,
  output logic      busReq,
  output logic      rspValid,
  output laneCtrl_t ctrl
);

  typedef enum logic {ST_IDLE, ST_WAIT} ctrlState_e;

  ctrlState_e state;

  always_comb begin
    ctrl.load   = (state == ST_IDLE) && cpuValid;
    ctrl.finish = (state == ST_WAIT) && busAck;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      rspValid <= 1'b0;
    end else begin
      rspValid <= ctrl.finish;
      unique case (state)
        ST_IDLE: if (ctrl.load)   state <= ST_WAIT;
        ST_WAIT: if (ctrl.finish) state <= ST_IDLE;
        default:                  state <= ST_IDLE;
      endcase
    end
  end

  assign busReq   = (state == ST_WAIT);
  assign cpuReady = (state == ST_IDLE);

endmodule

// File: rtl/lane_datapath.sv
module lane_datapath
  import lane_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  laneCtrl_t           ctrl,
  input  logic                cpuWrite,
  input  logic [ADDR_W-1:0]   cpuAddr,
  input  logic [1:0]          cpuSize,
  input  logic [DATA_W-1:0]   cpuWdata,
  output logic                busWe,
  output logic [ADDR_W-LIDX_W-1:0] busAddr,
  output logic [LANES-1:0]    busSel,
  output logic [DATA_W-1:0]   busWdata,
  input  logic [DATA_W-1:0]   busRdata,
  output logic [DATA_W-1:0]   rspRdata,
  output logic [1:0]          rspSize,
  output logic [1:0]          rspOffset
);

  localparam int WADDR_W = ADDR_W - LIDX_W;

  // ---------------- request encode ----------------
  logic [LIDX_W-1:0] offs;
  logic [LANES-1:0]  encSel;
  logic [LIDX_W-1:0] encLow;    // least significant lane in use
  logic [DATA_W-1:0] encWdata;

  assign offs = cpuAddr[LIDX_W-1:0];

  always_comb begin
    encSel = '0;
    encLow = '0;
    unique case (accSize_e'(cpuSize))
      SZ_BYTE: begin
        encSel = 4'b1000 >> offs;
        encLow = 2'd3 - offs;
      end
      SZ_HALF: begin
        encSel = offs[1] ? 4'b0011 : 4'b1100;
        encLow = offs[1] ? 2'd0 : 2'd2;
      end
      SZ_WORD: begin
        encSel = 4'b1111;
        encLow = 2'd0;
      end
      default: begin
        encSel = 4'b0000;
        encLow = 2'd0;
      end
    endcase
  end

  for (genvar i = 0; i < LANES; i++) begin : g_wlane
    localparam logic [LIDX_W-1:0] LI = LIDX_W'(i);
    logic [LIDX_W-1:0] srcIdx;
    assign srcIdx = LI - encLow;
    assign encWdata[i*LANE_W +: LANE_W] =
      encSel[i] ? cpuWdata[srcIdx*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busWe    <= 1'b0;
      busAddr  <= '0;
      busSel   <= '0;
      busWdata <= '0;
    end else if (ctrl.load) begin
      busWe    <= cpuWrite;
      busAddr  <= cpuAddr[ADDR_W-1:LIDX_W];
      busSel   <= encSel;
      busWdata <= encWdata;
    end
  end

  // ---------------- response decode ----------------
  logic [1:0]        decSize;
  logic [1:0]        decOffs;
  logic [LIDX_W-1:0] decLow;
  logic [2:0]        decCount;  // bytes returned, 0 for illegal select
  logic [DATA_W-1:0] extData;

  always_comb begin
    decSize  = SZ_BAD;
    decOffs  = 2'b11;
    decLow   = '0;
    decCount = 3'd0;
    unique case (busSel)
      4'b1000: begin decSize = SZ_BYTE; decOffs = 2'b00; decLow = 2'd3; decCount = 3'd1; end
      4'b0100: begin decSize = SZ_BYTE; decOffs = 2'b01; decLow = 2'd2; decCount = 3'd1; end
      4'b0010: begin decSize = SZ_BYTE; decOffs = 2'b10; decLow = 2'd1; decCount = 3'd1; end
      4'b0001: begin decSize = SZ_BYTE; decOffs = 2'b11; decLow = 2'd0; decCount = 3'd1; end
      4'b1100: begin decSize = SZ_HALF; decOffs = 2'b00; decLow = 2'd2; decCount = 3'd2; end
      4'b0011: begin decSize = SZ_HALF; decOffs = 2'b10; decLow = 2'd0; decCount = 3'd2; end
      4'b1111: begin decSize = SZ_WORD; decOffs = 2'b00; decLow = 2'd0; decCount = 3'd4; end
      default: begin decSize = SZ_BAD;  decOffs = 2'b11; decLow = 2'd0; decCount = 3'd0; end
    endcase
  end

  for (genvar j = 0; j < LANES; j++) begin : g_rlane
    localparam logic [LIDX_W-1:0] LJ = LIDX_W'(j);
    logic [LIDX_W-1:0] srcLane;
    assign srcLane = decLow + LJ;
    // zero fill above the access width, never sign extend
    assign extData[j*LANE_W +: LANE_W] =
      (3'(j) < decCount) ? busRdata[srcLane*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspRdata  <= '0;
      rspSize   <= '0;
      rspOffset <= '0;
    end else if (ctrl.finish) begin
      rspRdata  <= busWe ? '0 : extData;
      rspSize   <= decSize;
      rspOffset <= decOffs;
    end
  end

endmodule

// File: rtl/lane_bridge.sv
module lane_bridge
  import lane_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  output logic              cpuReady,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [1:0]        cpuSize,
  input  logic [31:0]       cpuWdata,
  output logic              busReq,
  output logic              busWe,
  output logic [ADDR_W-3:0] busAddr,
  output logic [3:0]        busSel,
  output logic [31:0]       busWdata,
  input  logic              busAck,
  input  logic [31:0]       busRdata,
  output logic              rspValid,
  output logic [31:0]       rspRdata,
  output logic [1:0]        rspSize,
  output logic [1:0]        rspOffset
);

  laneCtrl_t ctrl;

  lane_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cpuValid (cpuValid),
    .busAck   (busAck),
    .cpuReady (cpuReady),
    .busReq   (busReq),
    .rspValid (rspValid),
    .ctrl     (ctrl)
  );

  lane_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .cpuWrite  (cpuWrite),
    .cpuAddr   (cpuAddr),
    .cpuSize   (cpuSize),
    .cpuWdata  (cpuWdata),
    .busWe     (busWe),
    .busAddr   (busAddr),
    .busSel    (busSel),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .rspRdata  (rspRdata),
    .rspSize   (rspSize),
    .rspOffset (rspOffset)
  );

endmodule

// File: rtl/lane_bridge_chk.sv
module lane_bridge_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReady,
  input logic              busReq,
  input logic              busWe,
  input logic [ADDR_W-3:0] busAddr,
  input logic [3:0]        busSel,
  input logic [31:0]       busWdata,
  input logic              busAck,
  input logic              rspValid,
  input logic [31:0]       rspRdata,
  input logic [1:0]        rspSize
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busSel) && $stable(busWdata)
                          && $stable(busAddr) && $stable(busWe)); // R11

  AST_NOT_READY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> !cpuReady); // R11

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> ($onehot0(busSel) || busSel == 4'b1100 || busSel == 4'b0011
                || busSel == 4'b1111)); // R2

  AST_ACK_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busAck |=> rspValid && !busReq); // R12

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R12

  AST_BYTE_ZERO_FILL: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspSize == 2'b00 |-> rspRdata[31:8] == 24'h0); // R6

  AST_BAD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspSize == 2'b11 |-> rspRdata == 32'h0); // R8

  AST_UNUSED_LANES_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busSel == 4'b0011 |-> busWdata[31:16] == 16'h0); // R3

endmodule

bind lane_bridge lane_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cpuReady (cpuReady),
  .busReq   (busReq),
  .busWe    (busWe),
  .busAddr  (busAddr),
  .busSel   (busSel),
  .busWdata (busWdata),
  .busAck   (busAck),
  .rspValid (rspValid),
  .rspRdata (rspRdata),
  .rspSize  (rspSize)
);

// File: tb/sim_lane_bridge.sv
`timescale 1ns/1ps
module sim_lane_bridge;

  localparam int AW    = 12;
  localparam int NVEC  = 18;
  localparam int VEC_W = 77;

  // {write, offset, size, expSel, expWdata, expRdata, expSize, expOffset}
  localparam logic [VEC_W-1:0] VECS [NVEC] = '{
    {1'b1, 2'b00, 2'b00, 4'h8, 32'hD4000000, 32'h0, 2'b00, 2'b00},
    {1'b1, 2'b01, 2'b00, 4'h4, 32'h00D40000, 32'h0, 2'b00, 2'b01},
    {1'b1, 2'b10, 2'b00, 4'h2, 32'h0000D400, 32'h0, 2'b00, 2'b10},
    {1'b1, 2'b11, 2'b00, 4'h1, 32'h000000D4, 32'h0, 2'b00, 2'b11},
    {1'b1, 2'b00, 2'b01, 4'hC, 32'hC3D40000, 32'h0, 2'b01, 2'b00},
    {1'b1, 2'b01, 2'b01, 4'hC, 32'hC3D40000, 32'h0, 2'b01, 2'b00},
    {1'b1, 2'b10, 2'b01, 4'h3, 32'h0000C3D4, 32'h0, 2'b01, 2'b10},
    {1'b1, 2'b11, 2'b01, 4'h3, 32'h0000C3D4, 32'h0, 2'b01, 2'b10},
    {1'b1, 2'b01, 2'b10, 4'hF, 32'hA1B2C3D4, 32'h0, 2'b10, 2'b00},
    {1'b1, 2'b10, 2'b11, 4'h0, 32'h00000000, 32'h0, 2'b11, 2'b11},
    {1'b0, 2'b00, 2'b00, 4'h8, 32'h0, 32'h00000011, 2'b00, 2'b00},
    {1'b0, 2'b01, 2'b00, 4'h4, 32'h0, 32'h00000022, 2'b00, 2'b01},
    {1'b0, 2'b10, 2'b00, 4'h2, 32'h0, 32'h00000033, 2'b00, 2'b10},
    {1'b0, 2'b11, 2'b00, 4'h1, 32'h0, 32'h00000044, 2'b00, 2'b11},
    {1'b0, 2'b01, 2'b01, 4'hC, 32'h0, 32'h00001122, 2'b01, 2'b00},
    {1'b0, 2'b11, 2'b01, 4'h3, 32'h0, 32'h00003344, 2'b01, 2'b10},
    {1'b0, 2'b00, 2'b10, 4'hF, 32'h0, 32'h11223344, 2'b10, 2'b00},
    {1'b0, 2'b11, 2'b11, 4'h0, 32'h0, 32'h00000000, 2'b11, 2'b11}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cpuValid = 1'b0;
  logic          cpuReady;
  logic          cpuWrite = 1'b0;
  logic [AW-1:0] cpuAddr = '0;
  logic [1:0]    cpuSize = '0;
  logic [31:0]   cpuWdata = '0;
  logic          busReq;
  logic          busWe;
  logic [AW-3:0] busAddr;
  logic [3:0]    busSel;
  logic [31:0]   busWdata;
  logic          busAck = 1'b0;
  logic [31:0]   busRdata = '0;
  logic          rspValid;
  logic [31:0]   rspRdata;
  logic [1:0]    rspSize;
  logic [1:0]    rspOffset;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lane_bridge #(.ADDR_W(AW)) u0 (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string wrTag(input logic [1:0] sz);
    case (sz)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic string rdTag(input logic [1:0] sz);
    case (sz)
      2'b00: return "R6";
      2'b11: return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic runVec(input int idx);
    logic [VEC_W-1:0] v;
    logic          we;
    logic [1:0]    off, sz, eSz, eOff;
    logic [3:0]    eSel;
    logic [31:0]   eW, eR;
    logic [AW-3:0] wa;
    v = VECS[idx];
    {we, off, sz, eSel, eW, eR, eSz, eOff} = v;
    wa = (AW-2)'(10'h155 + idx * 7);
    @(negedge clk);
    cpuValid = 1'b1;
    cpuWrite = we;
    cpuAddr  = {wa, off};
    cpuSize  = sz;
    cpuWdata = we ? 32'hA1B2C3D4 : 32'h0;
    @(negedge clk);
    cpuValid = 1'b0;
    check(busReq === 1'b1 && cpuReady === 1'b0, "R11 req", {30'b0, busReq, cpuReady}, 32'h2);
    check(busWe === we, "R11 we", {31'b0, busWe}, {31'b0, we});
    check(busAddr === wa, "R11 addr", 32'(busAddr), 32'(wa));
    check(busSel === eSel, we ? wrTag(sz) : rdTag(sz), {28'b0, busSel}, {28'b0, eSel});
    if (we) check(busWdata === eW, wrTag(sz), busWdata, eW);
    busAck   = 1'b1;
    busRdata = 32'h11223344;
    @(negedge clk);
    busAck   = 1'b0;
    busRdata = 32'h0;
    check(rspValid === 1'b1 && busReq === 1'b0, "R12", {30'b0, rspValid, busReq}, 32'h2);
    check(rspRdata === eR, we ? "R12 wrdata" : rdTag(sz), rspRdata, eR);
    check(rspSize === eSz, "R9", {30'b0, rspSize}, {30'b0, eSz});
    check(rspOffset === eOff, "R10", {30'b0, rspOffset}, {30'b0, eOff});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busReq === 1'b0 && rspValid === 1'b0 && cpuReady === 1'b1, "R1 ctl",
          {29'b0, busReq, rspValid, cpuReady}, 32'h1);
    check(rspRdata === 32'h0 && rspSize === 2'b0 && rspOffset === 2'b0, "R1 rsp",
          rspRdata, 32'h0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) runVec(i);

    // R12: strobe lasts one cycle
    @(negedge clk);
    check(rspValid === 1'b0, "R12 pulse", {31'b0, rspValid}, 32'h0);

    // R11: stall acknowledge, offer a second request while busy
    cpuValid = 1'b1; cpuWrite = 1'b1; cpuAddr = 12'h3A6; cpuSize = 2'b00;
    cpuWdata = 32'h000000E7;
    @(negedge clk);
    cpuAddr = 12'h0F0; cpuSize = 2'b10; cpuWdata = 32'hFFFFFFFF;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(busReq === 1'b1 && cpuReady === 1'b0, "R11 busy", {30'b0, busReq, cpuReady}, 32'h2);
      check(busSel === 4'b0010, "R11 hold sel", {28'b0, busSel}, 32'h2);
      check(busWdata === 32'h0000E700, "R11 hold data", busWdata, 32'h0000E700);
      check(busAddr === 10'h0E9, "R11 hold addr", 32'(busAddr), 32'h0E9);
    end
    cpuValid = 1'b0;
    busAck = 1'b1;
    @(negedge clk);
    busAck = 1'b0;
    check(rspValid === 1'b1 && rspOffset === 2'b10 && rspSize === 2'b00, "R12 stalled rsp",
          {28'b0, rspValid, rspSize, rspOffset[0]}, 32'h8);
    @(negedge clk);
    check(busReq === 1'b0 && cpuReady === 1'b1, "R11 ignored while busy",
          {30'b0, busReq, cpuReady}, 32'h1);

    // R1: reset in flight
    cpuValid = 1'b1; cpuWrite = 1'b0; cpuSize = 2'b01; cpuAddr = 12'h002;
    @(negedge clk);
    cpuValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    check(busReq === 1'b0 && cpuReady === 1'b1 && busSel === 4'h0, "R1 mid reset",
          {27'b0, busSel, cpuReady}, 32'h1);
    rstN = 1'b1;

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule